// File: doc/BRIEF.md
# Armed Watchdog with Stretched First Window

This block is a timeout watchdog that raises an active-low backup flag when the supervised software stops servicing it. It has no reset output. A level input arms it. While that input is low, the watchdog does nothing and the flag is released. Each time the arm input goes high, the first timeout window is eight times longer than the programmed base period. This gives the software time to start before it has to service the watchdog.

Software services the watchdog with a falling edge on the service input, which arrives already filtered and synchronous to the clock. The flag asserts after three timeouts in a row with no service edge. The flag can also assert when the stretched first window runs out. It releases only after three service edges in a row that arrive under base-period timing. The base period is given in clock cycles on an input bus.

Top module: `armed_watchdog`

## Requirements
- R1: While `arm_i` is low, `backup_n_o` is 1 and falling edges on `kick_i` have no effect. This includes the length of the next stretched window.
- R2: After `arm_i` goes from 0 to 1, the first window lasts 8×P rising clock edges with `arm_i` high. P is `base_period_i`. With no service edge, `backup_n_o` goes to 0 on the 8×P-th edge and not before.
- R3: When the stretched window expires, `backup_n_o` goes to 0 at once and stays 0. Timing stays stretched until the next service edge.
- R4: In base timing, a timeout occurs P edges after the last restart. The third consecutive timeout with no service edge in between drives `backup_n_o` to 0.
- R5: A falling edge on `kick_i` (1 then 0 on consecutive clock samples) while armed restarts the timer. If it arrives during the stretched window, it switches timing to base period P at once.
- R6: A service edge that arrives under base timing is a good edge. `backup_n_o` returns to 1 on the clock edge of the third consecutive good edge.
- R7: A timeout zeroes the run of good edges. A service edge zeroes the run of timeouts.
- R8: When `arm_i` drops, the timer and both runs clear and `backup_n_o` is 1 after the next clock edge. The next rise of `arm_i` starts a new stretched window.
- R9: A `base_period_i` of 0 is treated as 1, so the stretched window is 8 cycles.
- R10: Synchronous active-high `rst` sets `backup_n_o` to 1 and selects the stretched window for the next armed period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Arm level; high runs the watchdog |
| kick_i | input | 1 | Service input; a falling edge services the watchdog |
| base_period_i | input | PERIOD_W | Base timeout period in clock cycles |
| backup_n_o | output | 1 | Backup flag, active low |

## Verification
On every cycle, the assertions check that an unarmed cycle leaves the flag released and that dropping the arm input restores the stretched window. They also check that a service edge always selects base timing, that the flag only falls on a timer expiry, and that it only rises on a good service edge. Exact window lengths, the counting of three timeouts and three good edges, the cross-resets of the two runs, and the zero-period case depend on counted cycle sequences. Only the bench's scenarios with a known period can show those.

// File: rtl/armwd_pkg.sv
package armwd_pkg;

    // Stretched first window is base period shifted left by this amount (x8).
    localparam int LONG_SHIFT   = 3;
    // Consecutive events needed to assert or release the backup flag.
    localparam int STRIKE_LIMIT = 3;
    localparam int RUN_W        = $clog2(STRIKE_LIMIT + 1);

    typedef enum logic {
        PER_LONG = 1'b0,
        PER_BASE = 1'b1
    } period_e;

    typedef logic [RUN_W-1:0] run_t;

    typedef struct packed {
        run_t miss_run;
        run_t good_run;
        logic flag;
    } strike_t;

    // Saturating increment of a run counter.
    function automatic run_t run_step(input run_t v);
        return (v == run_t'(STRIKE_LIMIT)) ? v : v + run_t'(1);
    endfunction

endpackage

// File: rtl/armwd_edge.sv
module armwd_edge (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic kick_i,
    output logic kick_fall_o
);
    logic kick_q;

    always_ff @(posedge clk) begin
        if (rst) kick_q <= 1'b0;
        else     kick_q <= kick_i;
    end

    // Edges seen while unarmed are dropped.
    assign kick_fall_o = arm_i && kick_q && !kick_i;

endmodule

// File: rtl/armwd_timer.sv
module armwd_timer
    import armwd_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_i,
    input  logic                kick_fall_i,
    input  logic [PERIOD_W-1:0] base_period_i,
    output logic                expire_o,
    output period_e             mode_o
);
    localparam int CNT_W = PERIOD_W + LONG_SHIFT;

    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    limit;
    logic [PERIOD_W-1:0] base_eff;
    period_e             mode_q;

    always_comb begin
        base_eff = (base_period_i == '0) ? PERIOD_W'(1) : base_period_i;
        if (mode_q == PER_LONG) limit = CNT_W'(base_eff) << LONG_SHIFT;
        else                    limit = CNT_W'(base_eff);
        expire_o = arm_i && !kick_fall_i && (cnt_q == limit - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            cnt_q  <= '0;
            mode_q <= PER_LONG;
        end else if (kick_fall_i) begin
            cnt_q  <= '0;
            mode_q <= PER_BASE;
        end else if (expire_o) begin
            cnt_q  <= '0;          // mode kept: a stretched window repeats until serviced
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/armwd_strike.sv
module armwd_strike
    import armwd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    arm_i,
    input  logic    kick_fall_i,
    input  logic    expire_i,
    input  period_e mode_i,
    output logic    flag_o
);
    strike_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!arm_i) begin
            st_d = '0;
        end else if (kick_fall_i) begin
            st_d.miss_run = '0;
            if (mode_i == PER_BASE) begin
                if (st_q.flag && st_q.good_run == run_t'(STRIKE_LIMIT - 1)) begin
                    st_d.flag     = 1'b0;
                    st_d.good_run = '0;
                end else begin
                    st_d.good_run = run_step(st_q.good_run);
                end
            end else begin
                st_d.good_run = '0;
            end
        end else if (expire_i) begin
            st_d.good_run = '0;
            st_d.miss_run = run_step(st_q.miss_run);
            if (mode_i == PER_LONG || st_q.miss_run >= run_t'(STRIKE_LIMIT - 1))
                st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/armed_watchdog.sv
module armed_watchdog
    import armwd_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_i,
    input  logic                kick_i,
    input  logic [PERIOD_W-1:0] base_period_i,
    output logic                backup_n_o
);
    logic    kick_fall;
    logic    expire;
    logic    flag;
    period_e mode;

    armwd_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .kick_i      (kick_i),
        .kick_fall_o (kick_fall)
    );

    armwd_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk           (clk),
        .rst           (rst),
        .arm_i         (arm_i),
        .kick_fall_i   (kick_fall),
        .base_period_i (base_period_i),
        .expire_o      (expire),
        .mode_o        (mode)
    );

    armwd_strike u_strike (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .kick_fall_i (kick_fall),
        .expire_i    (expire),
        .mode_i      (mode),
        .flag_o      (flag)
    );

    assign backup_n_o = !flag;

endmodule

// File: rtl/armwd_checker.sv
module armwd_checker
    import armwd_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    arm_i,
    input logic    backup_n_o,
    input logic    kick_fall,
    input logic    expire,
    input period_e mode
);
    logic past_ok;

    always_ff @(posedge clk) begin
        past_ok <= !rst;
    end

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(arm_i) |-> backup_n_o);

    assert_long_expiry_flags_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (expire && mode == PER_LONG) |=> !backup_n_o);

    assert_flag_from_expiry_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $fell(backup_n_o) |-> $past(expire));

    assert_kick_selects_base_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        kick_fall |=> (mode == PER_BASE));

    assert_release_on_good_kick_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($rose(backup_n_o) && $past(arm_i)) |-> ($past(kick_fall) && $past(mode) == PER_BASE));

    assert_disarm_restores_long_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !arm_i |=> (mode == PER_LONG));

endmodule

bind armed_watchdog armwd_checker i_armwd_checker (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (arm_i),
    .backup_n_o (backup_n_o),
    .kick_fall  (kick_fall),
    .expire     (expire),
    .mode       (mode)
);

// File: tb/test_armed_watchdog.sv
`timescale 1ns/1ps
module test_armed_watchdog;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          arm;
    logic          kick;
    logic [PW-1:0] period;
    logic          backup_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    armed_watchdog #(.PERIOD_W(PW)) i_armed_watchdog (
        .clk           (clk),
        .rst           (rst),
        .arm_i         (arm),
        .kick_i        (kick),
        .base_period_i (period),
        .backup_n_o    (backup_n)
    );

    // Vector: {arm, kick, edges[7:0], expected backup_n, requirement[3:0]}; base period 4.
    localparam int NV = 43;
    localparam logic [14:0] VECS [NV] = '{
        {1'b0,1'b1,8'd3 ,1'b1,4'd1},  // R1 idle
        {1'b1,1'b1,8'd31,1'b1,4'd2},  // R2 one short of 8x4
        {1'b1,1'b1,8'd1 ,1'b0,4'd3},  // R3 stretched expiry flags
        {1'b1,1'b1,8'd40,1'b0,4'd3},  // R3 stays flagged
        {1'b1,1'b0,8'd1 ,1'b0,4'd5},  // R5 kick in stretched window
        {1'b1,1'b1,8'd1 ,1'b0,4'd6},
        {1'b1,1'b0,8'd1 ,1'b0,4'd6},  // R6 good 1
        {1'b1,1'b1,8'd1 ,1'b0,4'd6},
        {1'b1,1'b0,8'd1 ,1'b0,4'd6},  // R6 good 2
        {1'b1,1'b1,8'd1 ,1'b0,4'd6},
        {1'b1,1'b0,8'd1 ,1'b1,4'd6},  // R6 good 3 releases
        {1'b1,1'b0,8'd11,1'b1,4'd4},  // R4 two timeouts
        {1'b1,1'b0,8'd1 ,1'b0,4'd4},  // R4 third timeout
        {1'b1,1'b1,8'd1 ,1'b0,4'd7},
        {1'b1,1'b0,8'd1 ,1'b0,4'd7},  // R7 good 1
        {1'b1,1'b1,8'd1 ,1'b0,4'd7},
        {1'b1,1'b0,8'd1 ,1'b0,4'd7},  // R7 good 2
        {1'b1,1'b0,8'd4 ,1'b0,4'd7},  // R7 timeout zeroes good run
        {1'b1,1'b1,8'd1 ,1'b0,4'd7},
        {1'b1,1'b0,8'd1 ,1'b0,4'd7},
        {1'b1,1'b1,8'd1 ,1'b0,4'd7},
        {1'b1,1'b0,8'd1 ,1'b0,4'd7},  // R7 only two fresh good edges
        {1'b1,1'b1,8'd1 ,1'b0,4'd6},
        {1'b1,1'b0,8'd1 ,1'b1,4'd6},  // R6 third fresh good edge
        {1'b1,1'b0,8'd8 ,1'b1,4'd7},  // two timeouts
        {1'b1,1'b1,8'd1 ,1'b1,4'd7},
        {1'b1,1'b0,8'd1 ,1'b1,4'd7},  // R7 edge zeroes timeout run
        {1'b1,1'b0,8'd11,1'b1,4'd7},
        {1'b1,1'b0,8'd1 ,1'b0,4'd7},
        {1'b0,1'b0,8'd1 ,1'b1,4'd8},  // R8 release next clock
        {1'b0,1'b1,8'd1 ,1'b1,4'd1},
        {1'b0,1'b0,8'd1 ,1'b1,4'd1},  // R1 edge while unarmed
        {1'b0,1'b1,8'd1 ,1'b1,4'd1},
        {1'b0,1'b0,8'd10,1'b1,4'd1},
        {1'b1,1'b0,8'd31,1'b1,4'd8},  // R8 new stretched window
        {1'b1,1'b0,8'd1 ,1'b0,4'd8},
        {1'b0,1'b1,8'd2 ,1'b1,4'd8},
        {1'b1,1'b1,8'd5 ,1'b1,4'd5},
        {1'b1,1'b0,8'd1 ,1'b1,4'd5},  // R5 early kick cuts window short
        {1'b1,1'b0,8'd3 ,1'b1,4'd5},
        {1'b1,1'b0,8'd1 ,1'b1,4'd5},
        {1'b1,1'b0,8'd7 ,1'b1,4'd5},
        {1'b1,1'b0,8'd1 ,1'b0,4'd5}
    };

    task automatic check(input logic exp, input int req, input string what);
        checks++;
        if (backup_n !== exp) begin
            errors++;
            $display("FAIL R%0d %s: backup_n_o=%0b expected %0b", req, what, backup_n, exp);
        end
    endtask

    task automatic step(input logic a, input logic k, input int n);
        arm  = a;
        kick = k;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; arm = 1'b0; kick = 1'b1; period = PW'(4);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(1'b1, 10, "after reset");  // R10

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][14], VECS[i][13], int'(VECS[i][12:5]));
            check(VECS[i][4], int'(VECS[i][3:0]), $sformatf("vector %0d", i));
        end

        // R10: reset while flagged releases and re-selects the stretched window
        arm = 1'b1;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(1'b1, 10, "reset while flagged");
        rst = 1'b0;
        step(1'b1, 1'b0, 31);
        check(1'b1, 10, "stretched after reset");
        step(1'b1, 1'b0, 1);
        check(1'b0, 10, "stretched expiry after reset");

        // R9: zero period behaves as one, stretched window of 8
        step(1'b0, 1'b0, 1);
        period = '0;
        step(1'b1, 1'b0, 7);
        check(1'b1, 9, "zero period, 7 edges");
        step(1'b1, 1'b0, 1);
        check(1'b0, 9, "zero period, 8 edges");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule